// File: doc/BRIEF.md
# Power Converter Fault Supervisor

This block decides when the switching stage of a power converter may run. Off-chip comparators turn the analog conditions into digital flags, and the block samples them on its clock. Three of the flags report where the supply stands against three levels: turn-on, PWM-off and shutdown. The other five report fault conditions:

- feedback above the open-loop level
- supply over-voltage
- current-sense input floating
- sampled output over-voltage
- over-temperature

The block drives three things: the PWM enable, the enable of the high-voltage startup current source, and a latched-fault status. It also reports, as a one-hot code, which fault caused the most recent shutdown.

The supply follows a hysteretic lockout with three states:

- **Waiting.** The startup source charges the supply.
- **Running.** PWM is allowed.
- **Draining.** PWM is off and the block waits for the supply to fall below the shutdown level.

Each fault flag must stay high for its own number of consecutive clocks before it counts. Open-loop, supply over-voltage and floating current-sense faults recover on their own: they end the current run, and the converter restarts after a full undervoltage cycle. Output over-voltage and over-temperature faults set a latch. That latch keeps PWM off across any number of supply cycles, and only the power-on reset input clears it.

Top module: `pwr_fault_supervisor`

## Requirements
- R1: While `rst_n` is low, `pwm_en` is 0, `startup_src_en` is 1, `latched_fault` is 0 and `fault_cause` is all zeros.
- R2: From the waiting state, the block enters the running state on the clock edge where `vdd_above_on` is sampled high. `startup_src_en` is 1 only in the waiting state, so it falls, and `pwm_en` rises, after that edge.
- R3: While running, `vdd_above_run` sampled low moves the block to the draining state. `pwm_en` is then 0 after that edge. It stays 0 even if `vdd_above_run` returns high, until the supply passes through the waiting state again.
- R4: `vdd_above_off` sampled low in the running or draining state returns the block to the waiting state. `startup_src_en` goes to 1, and PWM needs `vdd_above_on` again.
- R5: A fault trips only after its flag has been sampled high on N consecutive edges while running. N is `OLP_CYCLES`, `VOVP_CYCLES`, `CSF_CYCLES`, `OOVP_CYCLES` or `OTP_CYCLES`. A single low sample restarts that fault's count from zero.
- R6: An open-loop, supply over-voltage or current-sense-floating trip sets `pwm_en` to 0 after the tripping edge. PWM stays off until the supply drops below the shutdown level and rises past turn-on again; it then runs normally and `latched_fault` stays 0.
- R7: An output over-voltage or over-temperature trip sets `latched_fault` to 1 and holds `pwm_en` at 0 through any supply cycling. Only `rst_n` low clears it.
- R8: Fault counts advance only in the running state. A flag held high while waiting or draining has no effect, and the full count is needed after entering the running state.
- R9: `fault_cause` is one-hot and records the fault of the latest trip, held until the next trip or reset. The bit positions are:

  | Bit | Fault |
  |---|---|
  | 0 | open loop |
  | 1 | supply over-voltage |
  | 2 | current-sense floating |
  | 3 | output over-voltage |
  | 4 | over-temperature |

  When several faults trip on the same edge, the highest bit wins.
- R10: `pwm_en` and `startup_src_en` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low power-on reset; the only way to clear latched faults |
| vdd_above_on | input | 1 | Supply above the turn-on level |
| vdd_above_run | input | 1 | Supply above the PWM-off level |
| vdd_above_off | input | 1 | Supply above the shutdown level |
| vdd_ovp_flag | input | 1 | Supply over-voltage comparator |
| fb_high_flag | input | 1 | Feedback above the open-loop level |
| out_ovp_flag | input | 1 | Sampled output over-voltage comparator |
| otp_flag | input | 1 | Over-temperature detector |
| cs_float_flag | input | 1 | Current-sense input floating |
| pwm_en | output | 1 | PWM stage may switch |
| startup_src_en | output | 1 | Startup current source enabled |
| latched_fault | output | 1 | A latched fault is holding PWM off |
| fault_cause | output | 5 | One-hot cause of the latest fault shutdown |

## Verification
A wrong lockout state shows at the ports within one clock. The enable outputs are decoded directly from the registered state, so a missed transition leaves `pwm_en` or `startup_src_en` at the wrong level on the very next sample. A debounce counter that fails to clear, or counts outside the running state, makes `pwm_en` fall earlier than the exact edge its limit predicts. The bench therefore checks one cycle before and at the trip edge. A latch or cause register that is lost or cleared too early becomes visible once the bench runs a full supply cycle and finds PWM running again, or the cause vector changed.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    localparam int NUM_FAULTS = 5;

    // fault indices; a higher index wins when trips coincide
    localparam int F_OLP  = 0;
    localparam int F_VOVP = 1;
    localparam int F_CSF  = 2;
    localparam int F_OOVP = 3;
    localparam int F_OTP  = 4;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } sup_state_e;

    typedef struct packed {
        sup_state_e            st;
        logic                  latch;
        logic [NUM_FAULTS-1:0] cause;
    } sup_regs_t;

endpackage

// File: rtl/pfs_debounce.sv
module pfs_debounce #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic flag,
    output logic trip
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        trip  = enable && flag && (cnt_q == LAST);
        cnt_d = '0;
        if (enable && flag && !trip) begin
            cnt_d = cnt_q + 1'b1;
        end else if (trip) begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pfs_cause_pick.sv
module pfs_cause_pick
    import pfs_pkg::*;
(
    input  logic [NUM_FAULTS-1:0] trips,
    output logic [NUM_FAULTS-1:0] onehot
);
    always_comb begin
        onehot = '0;
        for (int i = 0; i < NUM_FAULTS; i++) begin
            if (trips[i]) begin
                onehot    = '0;
                onehot[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwr_fault_supervisor.sv
module pwr_fault_supervisor
    import pfs_pkg::*;
#(
    parameter int OLP_CYCLES  = 52000,
    parameter int VOVP_CYCLES = 150,
    parameter int CSF_CYCLES  = 150,
    parameter int OOVP_CYCLES = 4,
    parameter int OTP_CYCLES  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  vdd_above_on,
    input  logic                  vdd_above_run,
    input  logic                  vdd_above_off,
    input  logic                  vdd_ovp_flag,
    input  logic                  fb_high_flag,
    input  logic                  out_ovp_flag,
    input  logic                  otp_flag,
    input  logic                  cs_float_flag,
    output logic                  pwm_en,
    output logic                  startup_src_en,
    output logic                  latched_fault,
    output logic [NUM_FAULTS-1:0] fault_cause
);
    localparam int LIMITS [NUM_FAULTS] = '{OLP_CYCLES, VOVP_CYCLES, CSF_CYCLES,
                                           OOVP_CYCLES, OTP_CYCLES};

    sup_regs_t             r_d, r_q;
    logic [NUM_FAULTS-1:0] flags;
    logic [NUM_FAULTS-1:0] trips;
    logic [NUM_FAULTS-1:0] picked;
    logic                  counting;

    assign flags = {otp_flag, out_ovp_flag, cs_float_flag, vdd_ovp_flag, fb_high_flag};
    assign counting = (r_q.st == ST_RUN);

    for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_deb
        pfs_debounce #(.LIMIT(LIMITS[g])) deb_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (counting),
            .flag   (flags[g]),
            .trip   (trips[g])
        );
    end

    pfs_cause_pick pick_i (
        .trips  (trips),
        .onehot (picked)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_WAIT: begin
                if (vdd_above_on) r_d.st = ST_RUN;
            end
            ST_RUN: begin
                if (!vdd_above_off)                      r_d.st = ST_WAIT;
                else if (!vdd_above_run || (|trips))     r_d.st = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!vdd_above_off) r_d.st = ST_WAIT;
            end
            default: r_d.st = ST_WAIT;
        endcase
        if (|trips) r_d.cause = picked;
        if (trips[F_OOVP] || trips[F_OTP]) r_d.latch = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_WAIT;
            r_q.latch <= 1'b0;
            r_q.cause <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pwm_en         = (r_q.st == ST_RUN) && !r_q.latch;
    assign startup_src_en = (r_q.st == ST_WAIT);
    assign latched_fault  = r_q.latch;
    assign fault_cause    = r_q.cause;
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker
    import pfs_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  vdd_above_on,
    input logic                  vdd_above_run,
    input logic                  pwm_en,
    input logic                  startup_src_en,
    input logic                  latched_fault,
    input logic [NUM_FAULTS-1:0] fault_cause
);
    AST_SRC_PWM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_en && startup_src_en));  // R10

    AST_SRC_OFF_AT_ON: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_above_on |=> !startup_src_en);  // R2

    AST_RUNLEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !vdd_above_run |=> !pwm_en);  // R3

    AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        latched_fault |=> latched_fault);  // R7

    AST_LATCH_BLOCKS_PWM: assert property (@(posedge clk) disable iff (!rst_n)
        latched_fault |-> !pwm_en);  // R7

    AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fault_cause));  // R9
endmodule

bind pwr_fault_supervisor pfs_checker chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .vdd_above_on   (vdd_above_on),
    .vdd_above_run  (vdd_above_run),
    .pwm_en         (pwm_en),
    .startup_src_en (startup_src_en),
    .latched_fault  (latched_fault),
    .fault_cause    (fault_cause)
);

// File: tb/pwr_fault_supervisor_tb_top.sv
module pwr_fault_supervisor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int OLP  = 20;
    localparam int VOVP = 6;
    localparam int CSF  = 5;
    localparam int OOVP = 3;
    localparam int OTP  = 2;

    // {on, run, off, exp_pwm, exp_src}
    localparam logic [4:0] VEC [10] = '{
        5'b000_01, 5'b011_01, 5'b111_10, 5'b011_10, 5'b001_00,
        5'b011_00, 5'b000_01, 5'b111_10, 5'b000_01, 5'b111_10
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic on = 1'b0, run = 1'b0, off = 1'b0;
    logic vovp = 1'b0, fb = 1'b0, oovp = 1'b0, otp = 1'b0, csf = 1'b0;
    logic pwm_en, startup_src_en, latched_fault;
    logic [4:0] fault_cause;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_fault_supervisor #(
        .OLP_CYCLES(OLP), .VOVP_CYCLES(VOVP), .CSF_CYCLES(CSF),
        .OOVP_CYCLES(OOVP), .OTP_CYCLES(OTP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .vdd_above_on(on), .vdd_above_run(run), .vdd_above_off(off),
        .vdd_ovp_flag(vovp), .fb_high_flag(fb), .out_ovp_flag(oovp),
        .otp_flag(otp), .cs_float_flag(csf),
        .pwm_en(pwm_en), .startup_src_en(startup_src_en),
        .latched_fault(latched_fault), .fault_cause(fault_cause)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic supply(input logic a, input logic b, input logic c);
        on = a; run = b; off = c;
    endtask

    task automatic power_cycle;
        supply(0, 0, 0);
        step(1);
        check({7'd0, startup_src_en}, 8'd1, "R4 src on after shutdown");
        supply(1, 1, 1);
        step(1);
    endtask

    initial begin
        step(2);
        check({7'd0, pwm_en}, 8'd0, "R1 pwm in reset");
        check({7'd0, startup_src_en}, 8'd1, "R1 src in reset");
        check({7'd0, latched_fault}, 8'd0, "R1 latch in reset");
        check({3'd0, fault_cause}, 8'd0, "R1 cause in reset");
        rst_n = 1'b1;
        step(1);

        // supply sequencing table: R2 R3 R4
        for (int i = 0; i < 10; i++) begin
            supply(VEC[i][4], VEC[i][3], VEC[i][2]);
            step(1);
            check({7'd0, pwm_en}, {7'd0, VEC[i][1]}, $sformatf("R2/R3 pwm vec %0d", i));
            check({7'd0, startup_src_en}, {7'd0, VEC[i][0]}, $sformatf("R4 src vec %0d", i));
        end

        // open loop: debounce, restart of count, auto recovery
        fb = 1; step(OLP - 1);
        check({7'd0, pwm_en}, 8'd1, "R5 olp one short");
        fb = 0; step(1);
        fb = 1; step(OLP - 1);
        check({7'd0, pwm_en}, 8'd1, "R5 olp count restarted");
        step(1);
        check({7'd0, pwm_en}, 8'd0, "R5 olp trip");
        check({3'd0, fault_cause}, 8'h01, "R9 cause olp");
        check({7'd0, latched_fault}, 8'd0, "R6 olp not latched");
        fb = 0; step(2);
        check({7'd0, pwm_en}, 8'd0, "R6 olp stays off");
        power_cycle();
        check({7'd0, pwm_en}, 8'd1, "R6 olp recovered");

        // supply over-voltage
        vovp = 1; step(VOVP - 1);
        check({7'd0, pwm_en}, 8'd1, "R5 vovp one short");
        step(1);
        check({7'd0, pwm_en}, 8'd0, "R5 vovp trip");
        check({3'd0, fault_cause}, 8'h02, "R9 cause vovp");
        vovp = 0; step(3);
        check({7'd0, pwm_en}, 8'd0, "R6 vovp held until uv");
        power_cycle();
        check({7'd0, pwm_en}, 8'd1, "R6 vovp recovered");

        // current sense floating
        csf = 1; step(CSF - 1);
        check({7'd0, pwm_en}, 8'd1, "R5 csf one short");
        step(1);
        check({7'd0, pwm_en}, 8'd0, "R5 csf trip");
        check({3'd0, fault_cause}, 8'h04, "R9 cause csf");
        csf = 0;
        power_cycle();
        check({7'd0, pwm_en}, 8'd1, "R6 csf recovered");
        check({3'd0, fault_cause}, 8'h04, "R9 cause held across restart");

        // output over-voltage latches
        oovp = 1; step(OOVP);
        check({7'd0, pwm_en}, 8'd0, "R7 oovp trip");
        check({7'd0, latched_fault}, 8'd1, "R7 oovp latched");
        check({3'd0, fault_cause}, 8'h08, "R9 cause oovp");
        oovp = 0;
        power_cycle();
        check({7'd0, pwm_en}, 8'd0, "R7 pwm off after uv cycle");
        check({7'd0, latched_fault}, 8'd1, "R7 latch survives uv cycle");
        check({7'd0, startup_src_en}, 8'd0, "R10 src off while latched");
        rst_n = 0; step(1);
        check({7'd0, latched_fault}, 8'd0, "R1 reset clears latch");
        check({3'd0, fault_cause}, 8'h00, "R1 reset clears cause");
        check({7'd0, startup_src_en}, 8'd1, "R1 src after reset");
        rst_n = 1; step(1);
        check({7'd0, pwm_en}, 8'd1, "R7 runs after power-on reset");

        // over-temperature with coincident output over-voltage
        oovp = 1; step(1);
        otp = 1; step(OTP);
        check({3'd0, fault_cause}, 8'h10, "R9 priority otp over oovp");
        check({7'd0, latched_fault}, 8'd1, "R7 otp latched");
        check({7'd0, pwm_en}, 8'd0, "R7 otp pwm off");
        oovp = 0; otp = 0;
        rst_n = 0; step(1); rst_n = 1; step(1);
        check({7'd0, pwm_en}, 8'd1, "R7 restart after otp reset");

        // counting suppressed outside the running state
        supply(0, 0, 0); step(1);
        fb = 1; step(3 * OLP);
        check({7'd0, startup_src_en}, 8'd1, "R8 waiting with flag high");
        supply(1, 1, 1); step(1);
        check({7'd0, pwm_en}, 8'd1, "R8 pwm on entry");
        step(OLP - 1);
        check({7'd0, pwm_en}, 8'd1, "R8 full count still needed");
        step(1);
        check({7'd0, pwm_en}, 8'd0, "R8 trips at full count");
        check({3'd0, fault_cause}, 8'h01, "R9 cause olp again");
        fb = 0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule